// File: doc/BRIEF.md
# Hamming (7,4) Encoder and Single-Error Corrector

This block protects four-bit data values with a seven-bit single-error-correcting code. It has two independent paths that share one parity-mode input. The encode path takes a nibble and produces the seven-bit codeword. The correct path takes a received codeword and recomputes the three check groups to form a syndrome. It inverts the single bit that the syndrome names and returns three things: the repaired codeword, the recovered nibble and an error flag.

Each path ends in a one-entry output slot with two states. `SLOT_EMPTY` moves to `SLOT_FULL` when the path's input valid is high at a clock edge. `SLOT_FULL` stays in `SLOT_FULL` while further valid inputs arrive. Either state moves to `SLOT_EMPTY` on an edge where the input valid is low. The output valid is high exactly in `SLOT_FULL`. As a result, every accepted input appears one clock later for exactly one cycle, unless another input follows it directly.

Codeword bit index `i` holds code position `i+1`, so the seven-bit vector printed from its top bit down reads D7 D6 D5 P4 D3 P2 P1. The number of check bits is a parameter, and the default of three gives the (7,4) code.

Top module: `hm74_codec`

## Requirements
- R1: In an encoded word, data bit 3, bit 2, bit 1 and bit 0 sit at code positions 7, 6, 5 and 3 (vector bits 6, 5, 4 and 2). The check bits sit at positions 4, 2 and 1 (vector bits 3, 1 and 0).
- R2: With `odd_par`=0, the check bits are P1 = D3^D5^D7, P2 = D3^D6^D7 and P4 = D5^D6^D7. Nibble 4'b1001 encodes to 7'b1001100.
- R3: With `odd_par`=1, every check bit is the inverse of its even-mode value.
- R4: `enc_valid_o` is high in the cycle after an edge where `enc_valid_i` was high, and low after an edge where it was low. `enc_code_o` carries the encoding of the data and mode sampled at that edge.
- R5: The syndrome is {S4,S2,S1}. Each S bit is the XOR of every received bit in its group (positions whose index has that bit set), inverted when `odd_par`=1. A nonzero syndrome inverts the bit at the position it names and raises `dec_err_o`. In even mode, 7'b1101110 is repaired to 7'b1100110.
- R6: A codeword whose syndrome is zero is returned unchanged with `dec_err_o` low.
- R7: The correct path uses the same `odd_par` setting as the encode path. An odd-mode codeword is clean in odd mode, and a single flipped bit in it is repaired in odd mode.
- R8: `dec_data_o` is taken from positions 7, 6, 5 and 3 of the repaired word, with position 7 as its top bit.
- R9: `dec_valid_o` follows `dec_valid_i` one cycle later, as R4 does for the encode path. `dec_err_o` is never high while `dec_valid_o` is low.
- R10: While `rst_n` is low at a clock edge, all outputs are zero after that edge: both valids, both codewords, the nibble and the flag.
- R11: The two paths run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| odd_par | input | 1 | 0 selects even check bits, 1 selects odd |
| enc_valid_i | input | 1 | Encode request this cycle |
| enc_data_i | input | 4 | Nibble to encode |
| enc_valid_o | output | 1 | Encoded word present |
| enc_code_o | output | 7 | Encoded word, bit i is position i+1 |
| dec_valid_i | input | 1 | Correction request this cycle |
| dec_code_i | input | 7 | Received word, bit i is position i+1 |
| dec_valid_o | output | 1 | Correction result present |
| dec_code_o | output | 7 | Repaired word |
| dec_data_o | output | 4 | Recovered nibble |
| dec_err_o | output | 1 | A bit was inverted in this result |

## Verification
The bench corrupts every one of the seven positions of every nibble in both parity modes and checks the repair. A design with a misordered syndrome, or an off-by-one on position, would flip a neighbouring bit and leave two bad bits. Odd-mode clean words must pass with the flag low, which catches a checker that ignores the mode and reports every odd-mode word as damaged. Back-to-back requests, and an idle cycle after a request, expose a slot that drops a result or holds its valid high too long. Requests on both paths in the same cycle would reveal payloads crossing between the paths.

// File: rtl/hm74_pkg.sv
package hm74_pkg;

    localparam int MAX_POS = 63;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    function automatic bit is_check_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic int data_slot(int p);
        return p - $clog2(p + 1) - 1;
    endfunction

    function automatic logic [MAX_POS-1:0] cover_mask(int j);
        logic [MAX_POS-1:0] m;
        m = '0;
        for (int p = 1; p <= MAX_POS; p++) begin
            m[p-1] = ((p >> j) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hm74_slot.sv
module hm74_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] payload_i,
    output logic         valid_o,
    output logic [W-1:0] payload_o
);
    import hm74_pkg::*;

    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: state_d = load_i ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  state_d = load_i ? SLOT_FULL : SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      payload_o <= '0;
        else if (load_i) payload_o <= payload_i;
    end

    always_comb begin
        valid_o = (state_q == SLOT_FULL);
    end

endmodule

// File: rtl/hm74_encoder.sv
module hm74_encoder #(
    parameter  int CHECKS = 3,
    localparam int CODE_W = (1 << CHECKS) - 1,
    localparam int DATA_W = CODE_W - CHECKS
) (
    input  logic              odd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    import hm74_pkg::*;

    logic [CODE_W-1:0] spread;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        if (is_check_pos(p)) begin : g_chk
            localparam logic [CODE_W-1:0] MASK = CODE_W'(cover_mask($clog2(p)));
            assign spread[p-1] = 1'b0;
            assign code_o[p-1] = (^(spread & MASK)) ^ odd_i;
        end else begin : g_dat
            assign spread[p-1] = data_i[data_slot(p)];
            assign code_o[p-1] = spread[p-1];
        end
    end

endmodule

// File: rtl/hm74_corrector.sv
module hm74_corrector #(
    parameter  int CHECKS = 3,
    localparam int CODE_W = (1 << CHECKS) - 1,
    localparam int DATA_W = CODE_W - CHECKS
) (
    input  logic              odd_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] fixed_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);
    import hm74_pkg::*;

    logic [CHECKS-1:0] syn;
    logic [CODE_W-1:0] flip;

    for (genvar j = 0; j < CHECKS; j++) begin : g_syn
        localparam logic [CODE_W-1:0] MASK = CODE_W'(cover_mask(j));
        assign syn[j] = (^(code_i & MASK)) ^ odd_i;
    end

    always_comb begin
        flip = '0;
        if (syn != '0) flip = CODE_W'(1) << (syn - 1'b1);
    end

    assign fixed_o = code_i ^ flip;
    assign err_o   = |syn;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_out
        if (!is_check_pos(p)) begin : g_dat
            assign data_o[data_slot(p)] = fixed_o[p-1];
        end
    end

endmodule

// File: rtl/hm74_codec.sv
module hm74_codec #(
    parameter  int CHECKS = 3,
    localparam int CODE_W = (1 << CHECKS) - 1,
    localparam int DATA_W = CODE_W - CHECKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odd_par,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [CODE_W-1:0] dec_code_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_err_o
);
    localparam int DEC_W = 1 + DATA_W + CODE_W;

    logic [CODE_W-1:0] enc_word;
    logic [CODE_W-1:0] fix_word;
    logic [DATA_W-1:0] fix_data;
    logic              fix_err;
    logic [DEC_W-1:0]  dec_pay;
    logic              err_held;

    hm74_encoder #(.CHECKS(CHECKS)) u_enc (
        .odd_i  (odd_par),
        .data_i (enc_data_i),
        .code_o (enc_word)
    );

    hm74_slot #(.W(CODE_W)) u_enc_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (enc_valid_i),
        .payload_i (enc_word),
        .valid_o   (enc_valid_o),
        .payload_o (enc_code_o)
    );

    hm74_corrector #(.CHECKS(CHECKS)) u_fix (
        .odd_i   (odd_par),
        .code_i  (dec_code_i),
        .fixed_o (fix_word),
        .data_o  (fix_data),
        .err_o   (fix_err)
    );

    hm74_slot #(.W(DEC_W)) u_dec_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (dec_valid_i),
        .payload_i ({fix_err, fix_data, fix_word}),
        .valid_o   (dec_valid_o),
        .payload_o (dec_pay)
    );

    assign {err_held, dec_data_o, dec_code_o} = dec_pay;
    assign dec_err_o = err_held & dec_valid_o;

endmodule

// File: rtl/hm74_codec_chk.sv
module hm74_codec_chk #(
    parameter  int CHECKS = 3,
    localparam int CODE_W = (1 << CHECKS) - 1,
    localparam int DATA_W = CODE_W - CHECKS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              odd_par,
    input logic              enc_valid_i,
    input logic [DATA_W-1:0] enc_data_i,
    input logic              enc_valid_o,
    input logic [CODE_W-1:0] enc_code_o,
    input logic              dec_valid_i,
    input logic [CODE_W-1:0] dec_code_i,
    input logic              dec_valid_o,
    input logic [CODE_W-1:0] dec_code_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_err_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    function automatic logic [CHECKS-1:0] syn_of(logic [CODE_W-1:0] c, logic odd);
        logic [CHECKS-1:0] s;
        for (int j = 0; j < CHECKS; j++) begin
            s[j] = odd;
            for (int p = 1; p <= CODE_W; p++) begin
                if (((p >> j) & 1) == 1) s[j] = s[j] ^ c[p-1];
            end
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pick_data(logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = c[p-1];
                k++;
            end
        end
        return d;
    endfunction

    assert_enc_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed && enc_valid_o |-> pick_data(enc_code_o) == $past(enc_data_i));

    assert_enc_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && enc_valid_o |-> syn_of(enc_code_o, $past(odd_par)) == '0);

    assert_enc_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> enc_valid_o == $past(enc_valid_i));

    assert_dec_repair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && dec_valid_o |-> syn_of(dec_code_o, $past(odd_par)) == '0
                                 && $countones(dec_code_o ^ $past(dec_code_i)) <= 1);

    assert_dec_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && dec_valid_o |-> dec_err_o == (dec_code_o != $past(dec_code_i)));

    assert_dec_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> dec_data_o == pick_data(dec_code_o));

    assert_dec_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> dec_valid_o == $past(dec_valid_i));

    assert_err_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> dec_valid_o);

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> !enc_valid_o && !dec_valid_o && !dec_err_o
                   && enc_code_o == '0 && dec_code_o == '0);

endmodule

bind hm74_codec hm74_codec_chk #(.CHECKS(CHECKS)) u_chk (.*);

// File: tb/hm74_codec_bench.sv
module hm74_codec_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       odd_par = 1'b0;
    logic       enc_valid_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       enc_valid_o;
    logic [6:0] enc_code_o;
    logic       dec_valid_i = 1'b0;
    logic [6:0] dec_code_i = '0;
    logic       dec_valid_o;
    logic [6:0] dec_code_o;
    logic [3:0] dec_data_o;
    logic       dec_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hm74_codec u_hm74_codec (
        .clk         (clk),
        .rst_n       (rst_n),
        .odd_par     (odd_par),
        .enc_valid_i (enc_valid_i),
        .enc_data_i  (enc_data_i),
        .enc_valid_o (enc_valid_o),
        .enc_code_o  (enc_code_o),
        .dec_valid_i (dec_valid_i),
        .dec_code_i  (dec_code_i),
        .dec_valid_o (dec_valid_o),
        .dec_code_o  (dec_code_o),
        .dec_data_o  (dec_data_o),
        .dec_err_o   (dec_err_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference encoding: output {D7,D6,D5,P4,D3,P2,P1}
    function automatic logic [6:0] ref_enc(logic [3:0] d, logic odd);
        logic d7, d6, d5, d3, p1, p2, p4;
        d7 = d[3]; d6 = d[2]; d5 = d[1]; d3 = d[0];
        p1 = d3 ^ d5 ^ d7 ^ odd;
        p2 = d3 ^ d6 ^ d7 ^ odd;
        p4 = d5 ^ d6 ^ d7 ^ odd;
        return {d7, d6, d5, p4, d3, p2, p1};
    endfunction

    function automatic logic [2:0] ref_syn(logic [6:0] c, logic odd);
        logic s1, s2, s4;
        s1 = c[0] ^ c[2] ^ c[4] ^ c[6] ^ odd;
        s2 = c[1] ^ c[2] ^ c[5] ^ c[6] ^ odd;
        s4 = c[3] ^ c[4] ^ c[5] ^ c[6] ^ odd;
        return {s4, s2, s1};
    endfunction

    function automatic logic [6:0] ref_fix(logic [6:0] c, logic odd);
        logic [2:0] s;
        s = ref_syn(c, odd);
        if (s != 3'd0) c[s-1] = ~c[s-1];
        return c;
    endfunction

    // One encode request; outputs checked one cycle later (R4)
    task automatic run_enc(logic [3:0] d, logic odd, string req);
        @(negedge clk);
        enc_valid_i = 1'b1; enc_data_i = d; odd_par = odd;
        @(negedge clk);
        enc_valid_i = 1'b0;
        check({req, " enc valid R4"}, 32'(enc_valid_o), 32'd1);
        check({req, " enc code"}, 32'(enc_code_o), 32'(ref_enc(d, odd)));
    endtask

    task automatic run_dec(logic [6:0] c, logic odd, string req);
        logic [6:0] f;
        f = ref_fix(c, odd);
        @(negedge clk);
        dec_valid_i = 1'b1; dec_code_i = c; odd_par = odd;
        @(negedge clk);
        dec_valid_i = 1'b0;
        check({req, " dec valid R9"}, 32'(dec_valid_o), 32'd1);
        check({req, " dec code"}, 32'(dec_code_o), 32'(f));
        check({req, " dec nibble R8"}, 32'(dec_data_o), 32'({f[6], f[5], f[4], f[2]}));
        check({req, " dec flag"}, 32'(dec_err_o), 32'(ref_syn(c, odd) != 3'd0));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 enc_valid_o", 32'(enc_valid_o), 0);
        check("R10 enc_code_o", 32'(enc_code_o), 0);
        check("R10 dec_valid_o", 32'(dec_valid_o), 0);
        check("R10 dec_code_o", 32'(dec_code_o), 0);
        check("R10 dec_data_o", 32'(dec_data_o), 0);
        check("R10 dec_err_o", 32'(dec_err_o), 0);
    endtask

    task automatic t_examples;
        run_enc(4'b1001, 1'b0, "R2 example");
        check("R2 literal 1001100", 32'(enc_code_o), 32'(7'b1001100));
        run_dec(7'b1101110, 1'b0, "R5 example");
        check("R5 literal 1100110", 32'(dec_code_o), 32'(7'b1100110));
        check("R5 example flag", 32'(dec_err_o), 1);
        check("R8 example nibble", 32'(dec_data_o), 32'(4'b1101));
    endtask

    task automatic t_encode_all;
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 16; d++) begin
                run_enc(4'(d), 1'(m), m ? "R3 odd R1" : "R2 even R1");
                check("R1 data placement", 32'({enc_code_o[6], enc_code_o[5], enc_code_o[4], enc_code_o[2]}), 32'(d));
            end
        end
    endtask

    task automatic t_clean_words;
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 16; d++) begin
                run_dec(ref_enc(4'(d), 1'(m)), 1'(m), m ? "R7 odd clean R6" : "R6 even clean");
                check("R6 clean flag low", 32'(dec_err_o), 0);
            end
        end
    endtask

    task automatic t_single_flips;
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 16; d++) begin
                for (int p = 0; p < 7; p++) begin
                    logic [6:0] good;
                    good = ref_enc(4'(d), 1'(m));
                    run_dec(good ^ (7'd1 << p), 1'(m), m ? "R7 odd flip R5" : "R5 even flip");
                    check("R5 repaired to original", 32'(dec_code_o), 32'(good));
                    check("R5 flag high", 32'(dec_err_o), 1);
                end
            end
        end
    endtask

    task automatic t_gap_and_burst;
        // idle after a request: valid drops (R4, R9)
        run_enc(4'b0110, 1'b0, "R4 gap");
        @(negedge clk);
        check("R4 idle enc_valid_o low", 32'(enc_valid_o), 0);
        run_dec(7'b0000001, 1'b0, "R9 gap");
        @(negedge clk);
        check("R9 idle dec_valid_o low", 32'(dec_valid_o), 0);
        check("R9 idle dec_err_o low", 32'(dec_err_o), 0);
        // back-to-back encodes
        @(negedge clk);
        enc_valid_i = 1'b1; enc_data_i = 4'b0011; odd_par = 1'b0;
        @(negedge clk);
        enc_data_i = 4'b1110;
        check("R4 burst first valid", 32'(enc_valid_o), 1);
        check("R4 burst first code", 32'(enc_code_o), 32'(ref_enc(4'b0011, 1'b0)));
        @(negedge clk);
        enc_valid_i = 1'b0;
        check("R4 burst second valid", 32'(enc_valid_o), 1);
        check("R4 burst second code", 32'(enc_code_o), 32'(ref_enc(4'b1110, 1'b0)));
        @(negedge clk);
        check("R4 burst end", 32'(enc_valid_o), 0);
    endtask

    task automatic t_parallel;
        logic [6:0] bad;
        bad = ref_enc(4'b1010, 1'b1) ^ 7'b0100000;
        @(negedge clk);
        odd_par = 1'b1;
        enc_valid_i = 1'b1; enc_data_i = 4'b0101;
        dec_valid_i = 1'b1; dec_code_i = bad;
        @(negedge clk);
        enc_valid_i = 1'b0; dec_valid_i = 1'b0;
        check("R11 enc valid", 32'(enc_valid_o), 1);
        check("R11 enc code", 32'(enc_code_o), 32'(ref_enc(4'b0101, 1'b1)));
        check("R11 dec valid", 32'(dec_valid_o), 1);
        check("R11 dec code", 32'(dec_code_o), 32'(ref_enc(4'b1010, 1'b1)));
        check("R11 dec nibble", 32'(dec_data_o), 32'(4'b1010));
        check("R11 dec flag", 32'(dec_err_o), 1);
    endtask

    task automatic t_reset_mid;
        run_dec(7'b1111110, 1'b0, "R10 pre");
        @(negedge clk);
        rst_n = 1'b0; enc_valid_i = 1'b1; dec_valid_i = 1'b1;
        @(negedge clk);
        check("R10 mid enc_valid_o", 32'(enc_valid_o), 0);
        check("R10 mid dec_valid_o", 32'(dec_valid_o), 0);
        check("R10 mid dec_code_o", 32'(dec_code_o), 0);
        check("R10 mid dec_err_o", 32'(dec_err_o), 0);
        enc_valid_i = 1'b0; dec_valid_i = 1'b0; rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired");
        n_checks++;
        n_fail++;
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_examples();
        t_encode_all();
        t_clean_words();
        t_single_flips();
        t_gap_and_burst();
        t_parallel();
        t_reset_mid();
        run_enc(4'b1111, 1'b1, "R3 after reset");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule